// File: doc/BRIEF.md
# STS-3 Byte-Interleave Multiplexer

This block sits on the transmit side of a SONET/SDH mapper. It is the owner of a shared 9-bit transmit bus: 8 data bits plus a parity bit. It produces the bus timing. A one-hot grant tells each tributary source when its time slot is active. Three sync strobes mark the payload window, the frame and path-trace starts, and the start of the VT multiframe. Every tributary drives its byte in the cycle its grant is high. The block captures that byte, checks its parity, and can swap it for a high-order path overhead byte from a separate overhead port. The byte then leaves as one byte-interleaved stream.

Two modes exist. In STS-3 mode, three tributaries take turns byte by byte: slot 0, then 1, then 2, for each column. Each tributary row has 90 columns, and a frame has 9 rows. One output byte is produced per clock, and the block clock is the bus clock: 19.44 MHz in this mode. In single-STS-1 mode, only tributary 0 uses the bus, the clock is 6.48 MHz, and bytes pass through on a 90-column frame. The mode and the parity sense are static settings. They are changed only while reset is held.

Each tributary has a sticky parity error flag. Software clears a flag by writing a one to its clear bit.

Top module: `sts3_interleaver`

## Requirements
- R1: In STS-3 mode (`cfg_sts1`=0), the slot counter steps 0,1,2,0,... on every clock once running. `bus_grant[N]` alone is high in slot N, and a column advances after slot 2.
- R2: In single-STS-1 mode (`cfg_sts1`=1), `bus_grant` is 3'b001 every running cycle. The column advances every clock, and a frame is 9x90 clocks.
- R3: `out_data` equals the bus byte captured at the previous clock. Output bytes keep bus arrival order, unless R7 replaces one.
- R4: `bus_j0j1v1` is high at row 0, column 0, slot 0 (frame start). It is also high at row 0, column 3, in every slot (path trace byte). It is low everywhere else.
- R5: `bus_v1` is high at row 0, column 3, in every slot, only in frames whose count modulo 4 is 0. The first frame after reset has count 0.
- R6: `bus_spe` is high exactly for columns 3..89 of every row. It is low in columns 0..2.
- R7: `poh_req` is high exactly at column 3. At that moment, `poh_trib` gives the slot and `poh_row` gives the row, and `poh_data` is sampled. If `cfg_poh_en[slot]` is 1, the next output byte is `poh_data`. Otherwise it is the bus byte.
- R8: A byte is in error when the ones count of {`bus_data`,`bus_par`} is even with `cfg_par_odd`=1, or odd with `cfg_par_odd`=0. An error sets `par_err[slot]` from the next clock. Other flags are unchanged.
- R9: `par_err[i]` stays set until `par_err_clr[i]` is high at a clock edge. If a new error for tributary i arrives at that same edge, the flag stays set.
- R10: `out_j0` is high with the output byte that was captured at the frame start of R4, and only then. `out_spe` repeats `bus_spe` one clock later.
- R11: During reset, all grants, strobes, outputs and flags are 0. The first running position, one clock after reset release, is row 0, column 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sts1 | input | 1 | 1: single-STS-1 mode, 0: STS-3 mode |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_poh_en | input | 3 | Per-tributary path overhead replace enable |
| bus_grant | output | 3 | One-hot slot grant to tributary sources |
| bus_spe | output | 1 | Payload window strobe |
| bus_j0j1v1 | output | 1 | Frame start / path trace marker |
| bus_v1 | output | 1 | Multiframe marker |
| bus_data | input | 8 | Bus byte from granted tributary |
| bus_par | input | 1 | Bus parity bit |
| poh_req | output | 1 | Path overhead byte request |
| poh_trib | output | 2 | Tributary of the request |
| poh_row | output | 4 | Row of the request |
| poh_data | input | 8 | Path overhead byte |
| par_err | output | 3 | Sticky per-tributary parity error |
| par_err_clr | input | 3 | Write-one-to-clear for `par_err` |
| out_data | output | 8 | Interleaved output byte |
| out_j0 | output | 1 | Frame start marker on output |
| out_spe | output | 1 | Payload window marker on output |

## Verification
The bench runs four full STS-3 frames, so the multiframe marker must skip three frames and then come back. A counter that wraps in the wrong place would fire it every frame.

Odd parity is checked in STS-3 mode and even parity in STS-1 mode. Errors fall on varying slots, so a flag routed to the wrong tributary, or a wrong parity sense, shows up at once.

A clear is issued in the same clock as a new error. A design that lets the clear win would drop that flag.

Overhead replacement is enabled for only some tributaries. A merge that ignores the per-slot enable, or fires on the wrong column, puts the wrong bytes in the scoreboard comparison.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Parity bit that makes {data,par} meet the selected sense.
  function automatic logic ilv_par_bit(input logic [7:0] d, input logic odd);
    ilv_par_bit = odd ? ~(^d) : (^d);
  endfunction

  typedef enum logic {MODE_STS3 = 1'b0, MODE_STS1 = 1'b1} ilv_mode_e;

endpackage

// File: rtl/ilv_frame_timer.sv
module ilv_frame_timer #(
  parameter int NTRIB  = 3,
  parameter int COLS   = 90,
  parameter int ROWS   = 9,
  parameter int MF_LEN = 4,
  localparam int SLOT_W = (NTRIB > 1) ? $clog2(NTRIB) : 1,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int MF_W   = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts1,
  output logic              run,
  output logic [SLOT_W-1:0] slot,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row,
  output logic [MF_W-1:0]   mf
);
  import ilv_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NTRIB - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [MF_W-1:0]   MF_LAST   = MF_W'(MF_LEN - 1);

  ilv_mode_e         mode;
  logic [SLOT_W-1:0] slot_lim;
  logic              slot_wrap, col_wrap, row_wrap, mf_wrap;
  logic [SLOT_W-1:0] slot_nx;
  logic [COL_W-1:0]  col_nx;
  logic [ROW_W-1:0]  row_nx;
  logic [MF_W-1:0]   mf_nx;

  assign mode      = sts1 ? MODE_STS1 : MODE_STS3;
  assign slot_lim  = (mode == MODE_STS1) ? '0 : SLOT_LAST;
  assign slot_wrap = (slot == slot_lim);
  assign col_wrap  = (col == COL_LAST);
  assign row_wrap  = (row == ROW_LAST);
  assign mf_wrap   = (mf == MF_LAST);

  always_comb begin
    slot_nx = slot;
    col_nx  = col;
    row_nx  = row;
    mf_nx   = mf;
    if (run) begin
      if (slot_wrap) begin
        slot_nx = '0;
        if (col_wrap) begin
          col_nx = '0;
          if (row_wrap) begin
            row_nx = '0;
            mf_nx  = mf_wrap ? '0 : mf + 1'b1;
          end else begin
            row_nx = row + 1'b1;
          end
        end else begin
          col_nx = col + 1'b1;
        end
      end else begin
        slot_nx = slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      slot <= '0;
      col  <= '0;
      row  <= '0;
      mf   <= '0;
    end else begin
      run  <= 1'b1;
      slot <= slot_nx;
      col  <= col_nx;
      row  <= row_nx;
      mf   <= mf_nx;
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_LAST); // R1
  AST_STS1_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    sts1 |-> slot == '0); // R2
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slot_wrap) |=> $stable(col)); // R1
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row <= ROW_LAST && col <= COL_LAST); // R2

endmodule

// File: rtl/ilv_parity_chk.sv
module ilv_parity_chk #(
  parameter int NTRIB = 3,
  localparam int SLOT_W = (NTRIB > 1) ? $clog2(NTRIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              odd,
  input  logic [7:0]        data,
  input  logic              par,
  input  logic [SLOT_W-1:0] slot,
  input  logic [NTRIB-1:0]  clr,
  output logic [NTRIB-1:0]  err
);
  import ilv_pkg::*;

  logic             bad;
  logic [NTRIB-1:0] err_nx;

  assign bad = run && (par != ilv_par_bit(data, odd));

  for (genvar i = 0; i < NTRIB; i++) begin : g_flag
    always_comb begin
      err_nx[i] = err[i] & ~clr[i];
      if (bad && slot == SLOT_W'(i)) err_nx[i] = 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err[i] && !clr[i]) |=> err[i]); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!err[i] && !(bad && slot == SLOT_W'(i))) |=> !err[i]); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= '0;
    else        err <= err_nx;
  end

endmodule

// File: rtl/ilv_poh_merge.sv
module ilv_poh_merge #(
  parameter int NTRIB = 3,
  localparam int SLOT_W = (NTRIB > 1) ? $clog2(NTRIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              poh_slot,
  input  logic [SLOT_W-1:0] slot,
  input  logic [NTRIB-1:0]  poh_en,
  input  logic [7:0]        bus_byte,
  input  logic [7:0]        poh_byte,
  input  logic              j0_in,
  input  logic              spe_in,
  output logic [7:0]        out_byte,
  output logic              out_j0,
  output logic              out_spe
);

  logic       use_poh;
  logic [7:0] byte_nx;

  assign use_poh = poh_slot && poh_en[slot];
  assign byte_nx = use_poh ? poh_byte : bus_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte <= '0;
      out_j0   <= 1'b0;
      out_spe  <= 1'b0;
    end else if (run) begin
      out_byte <= byte_nx;
      out_j0   <= j0_in;
      out_spe  <= spe_in;
    end
  end

  AST_POH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && use_poh) |=> out_byte == $past(poh_byte)); // R7

endmodule

// File: rtl/sts3_interleaver.sv
module sts3_interleaver #(
  parameter int NTRIB   = 3,
  parameter int COLS    = 90,
  parameter int ROWS    = 9,
  parameter int MF_LEN  = 4,
  parameter int POH_COL = 3,
  localparam int SLOT_W = (NTRIB > 1) ? $clog2(NTRIB) : 1,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int MF_W   = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sts1,
  input  logic              cfg_par_odd,
  input  logic [NTRIB-1:0]  cfg_poh_en,
  output logic [NTRIB-1:0]  bus_grant,
  output logic              bus_spe,
  output logic              bus_j0j1v1,
  output logic              bus_v1,
  input  logic [7:0]        bus_data,
  input  logic              bus_par,
  output logic              poh_req,
  output logic [SLOT_W-1:0] poh_trib,
  output logic [ROW_W-1:0]  poh_row,
  input  logic [7:0]        poh_data,
  output logic [NTRIB-1:0]  par_err,
  input  logic [NTRIB-1:0]  par_err_clr,
  output logic [7:0]        out_data,
  output logic              out_j0,
  output logic              out_spe
);

  localparam logic [COL_W-1:0] POH_C = COL_W'(POH_COL);

  logic              run;
  logic [SLOT_W-1:0] slot;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [MF_W-1:0]   mf;
  logic              row0, at_j0, at_j1;

  ilv_frame_timer #(
    .NTRIB(NTRIB), .COLS(COLS), .ROWS(ROWS), .MF_LEN(MF_LEN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .sts1(cfg_sts1),
    .run(run), .slot(slot), .col(col), .row(row), .mf(mf)
  );

  for (genvar i = 0; i < NTRIB; i++) begin : g_grant
    assign bus_grant[i] = run && (slot == SLOT_W'(i));
  end

  assign row0       = run && (row == '0);
  assign at_j0      = row0 && (col == '0) && (slot == '0);
  assign at_j1      = row0 && (col == POH_C);
  assign bus_j0j1v1 = at_j0 || at_j1;
  assign bus_v1     = at_j1 && (mf == '0);
  assign bus_spe    = run && (col >= POH_C);
  assign poh_req    = run && (col == POH_C);
  assign poh_trib   = slot;
  assign poh_row    = row;

  ilv_parity_chk #(.NTRIB(NTRIB)) u_par (
    .clk(clk), .rst_n(rst_n), .run(run), .odd(cfg_par_odd),
    .data(bus_data), .par(bus_par), .slot(slot),
    .clr(par_err_clr), .err(par_err)
  );

  ilv_poh_merge #(.NTRIB(NTRIB)) u_merge (
    .clk(clk), .rst_n(rst_n), .run(run), .poh_slot(poh_req),
    .slot(slot), .poh_en(cfg_poh_en), .bus_byte(bus_data),
    .poh_byte(poh_data), .j0_in(at_j0), .spe_in(bus_spe),
    .out_byte(out_data), .out_j0(out_j0), .out_spe(out_spe)
  );

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant)); // R1
  AST_V1_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_v1 |-> bus_j0j1v1); // R5
  AST_POH_IN_SPE: assert property (@(posedge clk) disable iff (!rst_n)
    poh_req |-> bus_spe); // R7
  AST_OUT_J0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_j0j1v1 && !bus_spe) |=> out_j0); // R10
  AST_OUT_J0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_j0 |-> !out_spe); // R10
  AST_OUT_SPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> out_spe == $past(bus_spe)); // R10

endmodule

// File: tb/test_sts3_interleaver.sv
module test_sts3_interleaver;
  import ilv_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sts1 = 1'b0, cfg_par_odd = 1'b1;
  logic [2:0] cfg_poh_en = 3'b101;
  logic [2:0] bus_grant;
  logic       bus_spe, bus_j0j1v1, bus_v1;
  logic [7:0] bus_data = '0;
  logic       bus_par = 1'b0;
  logic       poh_req;
  logic [1:0] poh_trib;
  logic [3:0] poh_row;
  logic [7:0] poh_data;
  logic [2:0] par_err;
  logic [2:0] par_err_clr = '0;
  logic [7:0] out_data;
  logic       out_j0, out_spe;

  int errors = 0, checks = 0;
  int m_slot, m_col, m_row, m_mf, n;
  logic [2:0] exp_err;
  logic [9:0] sb[$];

  assign poh_data = {2'b10, poh_trib, poh_row};

  always #(CLK_PERIOD/2) clk = ~clk;

  sts3_interleaver i_sts3_interleaver (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (n=%0d)", req, act, exp, n);
    end
  endtask

  task automatic monitor();
    logic [9:0] e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk("R3/R7 out_data", out_data, e[7:0]);
      chk("R10 out_j0", out_j0, e[9]);
      chk("R10 out_spe", out_spe, e[8]);
    end
    chk("R8/R9 par_err", par_err, exp_err);
  endtask

  task automatic drive();
    logic [7:0] d, ed;
    logic bad, clr_all, j0, j1, slot_wrap;
    logic [2:0] g;
    g = 3'(1 << m_slot);
    j0 = (m_row == 0 && m_col == 0 && m_slot == 0);
    j1 = (m_row == 0 && m_col == 3);
    chk(cfg_sts1 ? "R2 grant" : "R1 grant", bus_grant, g);
    chk("R4 j0j1v1", bus_j0j1v1, j0 || j1);
    chk("R5 v1", bus_v1, j1 && m_mf == 0);
    chk("R6 spe", bus_spe, m_col >= 3);
    chk("R7 poh_req", poh_req, m_col == 3);
    if (m_col == 3) begin
      chk("R7 poh_trib", poh_trib, m_slot);
      chk("R7 poh_row", poh_row, m_row);
    end
    d = 8'(n * 37 + 11);
    bad = (n % 700 == 40);
    clr_all = (n % 700 == 300) || (n % 1400 == 740);
    bus_data = d;
    bus_par = ilv_par_bit(d, cfg_par_odd) ^ bad;
    par_err_clr = clr_all ? 3'b111 : 3'b000;
    exp_err = (exp_err & ~par_err_clr) | (bad ? g : 3'b000);
    ed = (m_col == 3 && cfg_poh_en[m_slot]) ? {2'b10, 2'(m_slot), 4'(m_row)} : d;
    sb.push_back({j0, (m_col >= 3), ed});
    slot_wrap = cfg_sts1 ? 1'b1 : (m_slot == 2);
    if (slot_wrap) begin
      m_slot = 0;
      if (m_col == 89) begin
        m_col = 0;
        if (m_row == 8) begin m_row = 0; m_mf = (m_mf + 1) % 4; end
        else m_row++;
      end else m_col++;
    end else m_slot++;
    n++;
  endtask

  task automatic run_phase(input logic sts1, input logic odd, input logic [2:0] pen,
                           input int cycles);
    rst_n = 1'b0;
    cfg_sts1 = sts1; cfg_par_odd = odd; cfg_poh_en = pen;
    par_err_clr = '0;
    sb.delete();
    repeat (3) @(negedge clk);
    chk("R11 reset grant", bus_grant, 0);
    chk("R11 reset strobes", {bus_spe, bus_j0j1v1, bus_v1, poh_req}, 0);
    chk("R11 reset out", {out_data, out_j0, out_spe}, 0);
    chk("R11 reset par_err", par_err, 0);
    rst_n = 1'b1;
    m_slot = 0; m_col = 0; m_row = 0; m_mf = 0; n = 0; exp_err = '0;
    @(posedge clk);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      monitor();
      drive();
    end
    @(negedge clk);
    monitor();
  endtask

  initial begin
    run_phase(1'b0, 1'b1, 3'b101, 4 * 2430 + 60);
    run_phase(1'b1, 1'b0, 3'b001, 2 * 810 + 60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule